// File: doc/BRIEF.md
# Passive SPI bus monitor

This block listens to an SPI bus and never drives it. SCK, MOSI, MISO and the chip select are treated as asynchronous signals and oversampled on a fast system clock. After synchronization, the block finds the SCK edge on which data is valid for the selected clock polarity and phase. It then shifts the MOSI and MISO bits in parallel into two words whose width and bit order are set by configuration inputs.

When a word is complete, both words appear on the outputs together. Alongside them come a flag that marks a word during which chip select was seen released, a one-cycle valid strobe and a free-running count of completed words. The outputs hold their values until the next word completes. A debug or trace path can therefore pick them up at any time after the strobe.

Top module: `spi_mon`

## Requirements
- R1: After reset, word_valid is 0, mosi_word and miso_word are all zero, cs_warn is 0 and word_count is 0.
- R2: The mode is {cfg_cpol,cfg_cpha} (00 = mode 0, 01 = mode 1, 10 = mode 2, 11 = mode 3). Bits are taken on the rising SCK edge in modes 0 and 3 and on the falling edge in modes 1 and 2. The other edge is ignored.
- R3: A sample is taken only when the synchronized SCK level differs from its previous level. The previous-level history resets to 1, so SCK held high through reset release produces no sample.
- R4: Each sampling edge captures MOSI and MISO at the same moment, each into its own word.
- R5: With cfg_lsb_first = 0 (MSB first), the k-th received bit (k from 0) lands at position WS-1-k. With cfg_lsb_first = 1 it lands at position k. Output bits at positions WS and above are 0.
- R6: The word size WS is cfg_word_size, with 0 treated as 1 and values above MAX_WS treated as MAX_WS. It is sampled only while no bit of a word has been received, so a change made in mid-word takes effect from the next word.
- R7: When the WS-th bit of a word is taken, word_valid pulses high for exactly one clock cycle. word_count increments by one on that pulse, wraps at 2^CNT_W and is otherwise unchanged.
- R8: mosi_word, miso_word and cs_warn change only together with word_valid and hold their values until the next word completes.
- R9: With cfg_cs_active_high = 0, chip select is asserted when bus_cs is 0; with 1, when bus_cs is 1. cs_warn is 1 for a word if bus_cs was at its inactive level on any sampling edge of that word. The flag starts clear for the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Clock polarity (idle level of SCK) |
| cfg_cpha | input | 1 | Clock phase (0: data valid on leading edge, 1: on trailing edge) |
| cfg_cs_active_high | input | 1 | Chip select polarity, 0 = active low |
| cfg_lsb_first | input | 1 | Bit order, 0 = MSB first |
| cfg_word_size | input | $clog2(MAX_WS+1) (7) | Requested bits per word |
| bus_sck | input | 1 | Observed SPI clock |
| bus_mosi | input | 1 | Observed controller-to-peripheral data |
| bus_miso | input | 1 | Observed peripheral-to-controller data |
| bus_cs | input | 1 | Observed chip select |
| word_valid | output | 1 | One-cycle strobe on word completion |
| mosi_word | output | MAX_WS (64) | Last completed MOSI word |
| miso_word | output | MAX_WS (64) | Last completed MISO word |
| cs_warn | output | 1 | Chip select released during the last word |
| word_count | output | CNT_W (16) | Completed-word counter |

## Verification
The bench builds the monitor with MAX_WS = 8 and CNT_W = 4. This lets it sweep every word size from 1 to 8 in all four modes and both bit orders. Across those runs the 4-bit word counter wraps several times. At each SCK edge that should not be sampled, the bench drives the inverted bit, so a wrong edge choice corrupts the captured word. A word size of 15 is out of range and exercises the upper clamp. Further runs cover a word-size change in mid-word, both chip-select polarities and a chip-select drop inside a word.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    typedef enum logic [1:0] {
        SPI_M0 = 2'b00,
        SPI_M1 = 2'b01,
        SPI_M2 = 2'b10,
        SPI_M3 = 2'b11
    } spi_mode_e;

    // True when the mode takes its data on the rising SCK edge.
    function automatic logic samples_on_rise(input spi_mode_e m);
        return (m == SPI_M0) || (m == SPI_M3);
    endfunction

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = async_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/spi_mon_edge.sv
module spi_mon_edge
    import spi_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cpol_i,
    input  logic cpha_i,
    output logic sample_o
);
    logic      prev_q, prev_d;
    logic      rise, fall;
    spi_mode_e mode;

    always_comb begin
        prev_d = sck_i;
        mode   = spi_mode_e'({cpol_i, cpha_i});
        rise   = sck_i & ~prev_q;
        fall   = ~sck_i & prev_q;
    end

    // History starts high: an idle-high clock yields no edge at reset release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign sample_o = samples_on_rise(mode) ? rise : fall;
endmodule

// File: rtl/spi_mon_core.sv
module spi_mon_core #(
    parameter int MAX_WS = 64,
    parameter int CNT_W  = 16,
    localparam int WSW   = $clog2(MAX_WS + 1),
    localparam int BCW   = (MAX_WS > 1) ? $clog2(MAX_WS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              mosi_i,
    input  logic              miso_i,
    input  logic              cs_i,
    input  logic              cs_active_high_i,
    input  logic              lsb_first_i,
    input  logic [WSW-1:0]    word_size_i,
    output logic              word_valid_o,
    output logic [MAX_WS-1:0] mosi_word_o,
    output logic [MAX_WS-1:0] miso_word_o,
    output logic              cs_warn_o,
    output logic [CNT_W-1:0]  word_count_o
);
    typedef struct packed {
        logic [BCW-1:0]    bitcnt;
        logic [WSW-1:0]    ws;
        logic [MAX_WS-1:0] mosi_sh;
        logic [MAX_WS-1:0] miso_sh;
        logic              warn_acc;
        logic [MAX_WS-1:0] mosi_out;
        logic [MAX_WS-1:0] miso_out;
        logic              warn_out;
        logic              valid;
        logic [CNT_W-1:0]  count;
    } core_state_t;

    core_state_t st_q, st_d;

    function automatic logic [WSW-1:0] clamp_ws(input logic [WSW-1:0] v);
        if (int'(v) == 0)      return WSW'(1);
        if (int'(v) > MAX_WS)  return WSW'(MAX_WS);
        return v;
    endfunction

    logic [WSW-1:0]    ws_req;
    logic [WSW-1:0]    cur_ws;
    logic              cs_inactive;
    logic              last_bit;
    logic [MAX_WS-1:0] mosi_n, miso_n;
    int                pos;

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        ws_req      = clamp_ws(word_size_i);
        cur_ws      = (int'(st_q.bitcnt) == 0) ? ws_req : st_q.ws;
        cs_inactive = cs_active_high_i ? ~cs_i : cs_i;
        last_bit    = (int'(st_q.bitcnt) == int'(cur_ws) - 1);
        pos         = lsb_first_i ? int'(st_q.bitcnt)
                                  : int'(cur_ws) - 1 - int'(st_q.bitcnt);
        mosi_n      = st_q.mosi_sh;
        miso_n      = st_q.miso_sh;
        mosi_n[pos[BCW-1:0]] = mosi_i;
        miso_n[pos[BCW-1:0]] = miso_i;

        // Size is frozen once the first bit of a word has arrived.
        if (int'(st_q.bitcnt) == 0) st_d.ws = ws_req;

        if (sample_i) begin
            if (last_bit) begin
                st_d.mosi_out = mosi_n;
                st_d.miso_out = miso_n;
                st_d.warn_out = st_q.warn_acc | cs_inactive;
                st_d.valid    = 1'b1;
                st_d.count    = st_q.count + CNT_W'(1);
                st_d.mosi_sh  = '0;
                st_d.miso_sh  = '0;
                st_d.warn_acc = 1'b0;
                st_d.bitcnt   = '0;
            end else begin
                st_d.mosi_sh  = mosi_n;
                st_d.miso_sh  = miso_n;
                st_d.warn_acc = st_q.warn_acc | cs_inactive;
                st_d.bitcnt   = st_q.bitcnt + BCW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ws <= WSW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign word_valid_o = st_q.valid;
    assign mosi_word_o  = st_q.mosi_out;
    assign miso_word_o  = st_q.miso_out;
    assign cs_warn_o    = st_q.warn_out;
    assign word_count_o = st_q.count;
endmodule

// File: rtl/spi_mon.sv
module spi_mon #(
    parameter int MAX_WS = 64,
    parameter int CNT_W  = 16,
    localparam int WSW   = $clog2(MAX_WS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_cs_active_high,
    input  logic              cfg_lsb_first,
    input  logic [WSW-1:0]    cfg_word_size,
    input  logic              bus_sck,
    input  logic              bus_mosi,
    input  logic              bus_miso,
    input  logic              bus_cs,
    output logic              word_valid,
    output logic [MAX_WS-1:0] mosi_word,
    output logic [MAX_WS-1:0] miso_word,
    output logic              cs_warn,
    output logic [CNT_W-1:0]  word_count
);
    logic [3:0] bus_sync;
    logic       samp_pulse;

    // Order: {sck, mosi, miso, cs}; clock and chip select idle high.
    spi_mon_sync #(
        .W       (4),
        .RST_VAL (4'b1001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_sck, bus_mosi, bus_miso, bus_cs}),
        .sync_o  (bus_sync)
    );

    spi_mon_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (bus_sync[3]),
        .cpol_i   (cfg_cpol),
        .cpha_i   (cfg_cpha),
        .sample_o (samp_pulse)
    );

    spi_mon_core #(
        .MAX_WS (MAX_WS),
        .CNT_W  (CNT_W)
    ) u_core (
        .clk              (clk),
        .rst_n            (rst_n),
        .sample_i         (samp_pulse),
        .mosi_i           (bus_sync[2]),
        .miso_i           (bus_sync[1]),
        .cs_i             (bus_sync[0]),
        .cs_active_high_i (cfg_cs_active_high),
        .lsb_first_i      (cfg_lsb_first),
        .word_size_i      (cfg_word_size),
        .word_valid_o     (word_valid),
        .mosi_word_o      (mosi_word),
        .miso_word_o      (miso_word),
        .cs_warn_o        (cs_warn),
        .word_count_o     (word_count)
    );
endmodule

// File: rtl/spi_mon_chk.sv
module spi_mon_chk #(
    parameter int MAX_WS = 64,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp,
    input logic              word_valid,
    input logic [MAX_WS-1:0] mosi_word,
    input logic [MAX_WS-1:0] miso_word,
    input logic              cs_warn,
    input logic [CNT_W-1:0]  word_count
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> word_count == CNT_W'($past(word_count) + CNT_W'(1))); // R7

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_count)); // R7

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ($stable(mosi_word) && $stable(miso_word) && $stable(cs_warn))); // R8

    AST_VALID_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(samp)); // R2
endmodule

bind spi_mon spi_mon_chk #(
    .MAX_WS (MAX_WS),
    .CNT_W  (CNT_W)
) u_spi_mon_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp       (samp_pulse),
    .word_valid (word_valid),
    .mosi_word  (mosi_word),
    .miso_word  (miso_word),
    .cs_warn    (cs_warn),
    .word_count (word_count)
);

// File: tb/spi_mon_bench.sv
`timescale 1ns/1ps
module spi_mon_bench;
    localparam int MAX_WS = 8;
    localparam int CNT_W  = 4;
    localparam int WSW    = $clog2(MAX_WS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_cpol = 1'b0;
    logic              cfg_cpha = 1'b0;
    logic              cfg_cs_active_high = 1'b0;
    logic              cfg_lsb_first = 1'b0;
    logic [WSW-1:0]    cfg_word_size = WSW'(8);
    logic              bus_sck = 1'b1;
    logic              bus_mosi = 1'b0;
    logic              bus_miso = 1'b0;
    logic              bus_cs = 1'b0;
    logic              word_valid;
    logic [MAX_WS-1:0] mosi_word;
    logic [MAX_WS-1:0] miso_word;
    logic              cs_warn;
    logic [CNT_W-1:0]  word_count;

    spi_mon #(.MAX_WS(MAX_WS), .CNT_W(CNT_W)) u_spi_mon (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_cs_active_high(cfg_cs_active_high), .cfg_lsb_first(cfg_lsb_first),
        .cfg_word_size(cfg_word_size),
        .bus_sck(bus_sck), .bus_mosi(bus_mosi), .bus_miso(bus_miso), .bus_cs(bus_cs),
        .word_valid(word_valid), .mosi_word(mosi_word), .miso_word(miso_word),
        .cs_warn(cs_warn), .word_count(word_count)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int dbl = 0;
    int exp_count = 0;
    logic prev_valid = 1'b0;
    logic [7:0] prev_mo = 8'h00;
    logic [7:0] prev_mi = 8'h00;
    logic       prev_warn = 1'b0;
    bit done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulses <= 0; dbl <= 0; prev_valid <= 1'b0;
        end else begin
            if (word_valid) pulses <= pulses + 1;
            if (word_valid && prev_valid) dbl <= dbl + 1;
            prev_valid <= word_valid;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic cpol, input logic cpha);
        @(negedge clk);
        rst_n = 1'b0;
        bus_sck = 1'b1;
        cfg_cpol = cpol;
        cfg_cpha = cpol;        // rising-edge mode while the clock settles
        tick(4);
        rst_n = 1'b1;
        tick(4);
        bus_sck = cpol;
        tick(6);
        cfg_cpha = cpha;
        tick(2);
        exp_count = 0;
        prev_mo = 8'h00; prev_mi = 8'h00; prev_warn = 1'b0;
    endtask

    // Sends nbits; on the non-sampling edge the inverted bit is on the wires.
    task automatic send_word(input int nbits, input logic [7:0] mo, input logic [7:0] mi,
                             input int drop_bit, input int new_ws);
        logic cs_on;
        logic mb, ib;
        logic [7:0] mask;
        int b;
        cs_on = cfg_cs_active_high;
        mask = 8'((1 << nbits) - 1);
        for (int k = 0; k < nbits; k++) begin
            b = cfg_lsb_first ? k : nbits - 1 - k;
            mb = mo[b]; ib = mi[b];
            bus_cs = (k == drop_bit) ? ~cs_on : cs_on;
            bus_mosi = cfg_cpha ? ~mb : mb;
            bus_miso = cfg_cpha ? ~ib : ib;
            tick(3);
            bus_sck = ~bus_sck;
            tick(3);
            bus_mosi = cfg_cpha ? mb : ~mb;
            bus_miso = cfg_cpha ? ib : ~ib;
            tick(3);
            bus_sck = ~bus_sck;
            tick(3);
            if (k == 0 && new_ws != 0) cfg_word_size = WSW'(new_ws);
            if (k == 0 && nbits > 1) begin
                chk("R8 mosi held mid-word", 64'(mosi_word), 64'(prev_mo));
                chk("R8 miso held mid-word", 64'(miso_word), 64'(prev_mi));
                chk("R8 warn held mid-word", 64'(cs_warn), 64'(prev_warn));
            end
        end
        bus_cs = cs_on;
        tick(6);
        exp_count++;
        chk("R2 R3 R4 R5 R6 mosi_word", 64'(mosi_word), 64'(mo & mask));
        chk("R2 R3 R4 R5 R6 miso_word", 64'(miso_word), 64'(mi & mask));
        chk("R9 cs_warn", 64'(cs_warn), 64'(drop_bit >= 0));
        chk("R7 word_count", 64'(word_count), 64'(exp_count % (1 << CNT_W)));
        chk("R7 valid pulses", 64'(pulses), 64'(exp_count));
        chk("R7 single-cycle strobe", 64'({dbl, word_valid}), 64'(0));
        prev_mo = mo & mask; prev_mi = mi & mask; prev_warn = (drop_bit >= 0);
    endtask

    initial begin
        logic [7:0] mo, mi;
        for (int mode = 0; mode < 4; mode++) begin
            cfg_cs_active_high = 1'b0;
            do_reset(logic'(mode >> 1), logic'(mode & 1));
            chk("R1 reset count", 64'(word_count), 64'(0));
            chk("R1 reset words", 64'({mosi_word, miso_word}), 64'(0));
            chk("R1 reset warn/valid", 64'({cs_warn, word_valid}), 64'(0));
            chk("R3 no sample from idle clock", 64'(pulses), 64'(0));
            for (int lsb = 0; lsb < 2; lsb++) begin
                cfg_lsb_first = logic'(lsb);
                for (int ws = 1; ws <= MAX_WS; ws++) begin
                    cfg_word_size = WSW'(ws);
                    mo = 8'(ws * 29 + mode * 53 + lsb * 17 + 8'h5A);
                    mi = ~mo ^ 8'(ws * 7);
                    send_word(ws, mo, mi, (ws == 5) ? 2 : -1, 0);
                end
            end
        end

        // R6: clamping and mid-word size change (mode 0, MSB first).
        do_reset(1'b0, 1'b0);
        cfg_lsb_first = 1'b0;
        cfg_word_size = WSW'(0);
        send_word(1, 8'h01, 8'h00, -1, 0);
        send_word(1, 8'h00, 8'h01, -1, 0);
        cfg_word_size = WSW'(15);
        send_word(8, 8'hC3, 8'h3C, -1, 0);
        cfg_word_size = WSW'(4);
        send_word(4, 8'h0B, 8'h04, -1, 8);
        send_word(8, 8'h96, 8'h69, -1, 0);

        // R9: active-high chip select.
        cfg_cs_active_high = 1'b1;
        bus_cs = 1'b1;
        tick(4);
        send_word(8, 8'h5E, 8'hE5, -1, 0);
        send_word(8, 8'h71, 8'h17, 7, 0);
        send_word(8, 8'h22, 8'hDD, -1, 0);
        send_word(8, 8'hA0, 8'h0A, 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule